// File: doc/BRIEF.md
# Page Permission Check and Address Formation

This block sits after the translation lookup. It receives one matched page entry together with the effective address of an access. From these it forms the 32-bit real address and decides whether the access may go ahead. The entry supplies a 4-bit page-size code, a 22-bit real page number and six rights bits. The page-size code selects how many low effective-address bits pass through as the page offset. The remaining high address bits come from the page number. Rights are chosen per access class: execute for fetches, read for loads, and write for stores and for the store-class block-zero operation. The privilege bit picks either the user copy or the supervisor copy of each right.

If an entry has an unsupported size code, or has page-number bits set where the chosen offset covers them, it is flagged as invalid, and that flag overrides every permission. A denied fetch raises an execute-violation flag. The consumer uses that flag to request an instruction storage interrupt and must not fetch or fill a cache. A denied load or store raises a data-violation flag. Each result is registered behind a valid/ready handshake. A two-state holding machine has the states IDLE (no result held) and HELD (a result waits for the consumer). Its transitions are: IDLE to HELD when an input is accepted, HELD to HELD when the result is consumed and a new input is accepted in the same cycle, HELD to HELD when the result is held because the consumer is not ready, and HELD to IDLE when the result is consumed and no new input arrives.

Top module: `page_guard`

## Requirements
- R1: Page-size codes give these offset widths: 0→10, 1→12, 2→14, 3→16, 4→18, 5→20, 7→24 and 9→28 bits. For a granted access, `out_ra` equals `in_rpn` (bit 21 maps to address bit 31) in the address bits above the offset width, and equals `in_ea` in the offset bits.
- R2: Size codes 6, 8 and 10 to 15 set `out_bad` and clear `out_grant`.
- R3: If any page-number bit that falls inside the offset is set, the entry sets `out_bad` and clears `out_grant`. For a width of w bits, these are the low w−10 bits of `in_rpn`.
- R4: A fetch (`in_acc`=0) uses `in_perm[5]` (user execute) when `in_user`=1 and `in_perm[2]` (supervisor execute) when `in_user`=0. If the selected bit is 0, the access sets `out_xviol` and clears `out_grant`.
- R5: A load (`in_acc`=1) uses `in_perm[3]` (user read) or `in_perm[0]` (supervisor read), chosen by `in_user`. If the selected bit is 0, the access sets `out_dviol` and clears `out_grant`.
- R6: A store (`in_acc`=2) and a block-zero operation (`in_acc`=3) both use `in_perm[4]` (user write) or `in_perm[1]` (supervisor write), chosen by `in_user`. If the selected bit is 0, the access sets `out_dviol` and clears `out_grant`.
- R7: When `out_bad` is 1, both `out_xviol` and `out_dviol` are 0, whatever the rights bits hold. At most one of the three flags is set.
- R8: When `out_grant` is 0, `out_ra` is zero.
- R9: A result appears on the outputs in the cycle after its input is accepted (`in_valid` and `in_ready` both 1 at a clock edge). It stays unchanged while `out_valid` is 1 and `out_ready` is 0, and `in_ready` is 0 for as long as the result is held.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Access request present |
| in_ready | output | 1 | Block can accept a request |
| in_ea | input | 32 | Effective address |
| in_acc | input | 2 | 0 fetch, 1 load, 2 store, 3 block zero |
| in_user | input | 1 | 1 user mode, 0 supervisor mode |
| in_size | input | 4 | Page-size code of the entry |
| in_rpn | input | 22 | Real page number of the entry |
| in_perm | input | 6 | Rights: [5] UX, [4] UW, [3] UR, [2] SX, [1] SW, [0] SR |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ra | output | 32 | Real address (zero when not granted) |
| out_grant | output | 1 | Access allowed |
| out_xviol | output | 1 | Execute violation |
| out_dviol | output | 1 | Data read/write violation |
| out_bad | output | 1 | Unsupported size or misaligned page number |

## Verification
All results are due exactly one clock edge after acceptance. The bench drives each request on a falling edge, lets one rising edge accept it, and compares all five result outputs at the next falling edge. During the stall test the consumer is held not ready for several cycles, and the bench confirms at each falling edge that the held result stays put and that `in_ready` stays low. When the consumer becomes ready, the bench checks that the queued request appears one edge after that release.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ZERO  = 2'd3
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } hold_state_t;

    // right classes, index into per-mode triples of the rights field
    localparam int RIGHT_READ  = 0;
    localparam int RIGHT_WRITE = 1;
    localparam int RIGHT_EXEC  = 2;
    localparam int RIGHT_N     = 3;

endpackage

// File: rtl/pg_size_decode.sv
module pg_size_decode #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4,
    parameter int OFFW_W = $clog2(ADDR_W + 1)
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic              legal,
    output logic [OFFW_W-1:0] off_w,
    output logic [ADDR_W-1:0] off_mask
);
    always_comb begin
        legal = 1'b1;
        off_w = '0;
        unique case (size_code)
            4'd0:    off_w = OFFW_W'(10);
            4'd1:    off_w = OFFW_W'(12);
            4'd2:    off_w = OFFW_W'(14);
            4'd3:    off_w = OFFW_W'(16);
            4'd4:    off_w = OFFW_W'(18);
            4'd5:    off_w = OFFW_W'(20);
            4'd7:    off_w = OFFW_W'(24);
            4'd9:    off_w = OFFW_W'(28);
            default: legal = 1'b0;
        endcase
    end

    // offset mask: one bit per address position below the offset width
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign off_mask[i] = (OFFW_W'(i) < off_w);
    end
endmodule

// File: rtl/pg_rights.sv
module pg_rights
    import pg_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       user,
    input  logic [5:0] perm,
    output logic       allow,
    output logic       is_fetch
);
    logic [RIGHT_N-1:0] eff;

    // per-class choice between user copy (upper triple) and supervisor copy
    for (genvar k = 0; k < RIGHT_N; k++) begin : g_sel
        assign eff[k] = user ? perm[RIGHT_N + k] : perm[k];
    end

    always_comb begin
        allow    = 1'b0;
        is_fetch = 1'b0;
        unique case (acc_kind_t'(acc))
            ACC_FETCH: begin
                allow    = eff[RIGHT_EXEC];
                is_fetch = 1'b1;
            end
            ACC_LOAD:  allow = eff[RIGHT_READ];
            ACC_STORE: allow = eff[RIGHT_WRITE];
            ACC_ZERO:  allow = eff[RIGHT_WRITE];
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/pg_hold_stage.sv
module pg_hold_stage
    import pg_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    hold_state_t state_q, state_d;
    logic        take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_HELD;
            end
            ST_HELD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= in_data;
    end
endmodule

// File: rtl/page_guard.sv
module page_guard #(
    parameter int ADDR_W = 32,
    parameter int RPN_W  = 22,
    parameter int SIZE_W = 4,
    parameter int PERM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_ea,
    input  logic [1:0]        in_acc,
    input  logic              in_user,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [RPN_W-1:0]  in_rpn,
    input  logic [PERM_W-1:0] in_perm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_ra,
    output logic              out_grant,
    output logic              out_xviol,
    output logic              out_dviol,
    output logic              out_bad
);
    localparam int BASE_W = ADDR_W - RPN_W;
    localparam int OFFW_W = $clog2(ADDR_W + 1);
    localparam int RES_W  = ADDR_W + 4;

    logic              size_ok, allow, is_fetch, misaligned, bad, grant;
    logic [OFFW_W-1:0] off_w;
    logic [ADDR_W-1:0] off_mask, page_base, ra;
    logic [RES_W-1:0]  res_d, res_q;

    pg_size_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFFW_W(OFFW_W)) u_size (
        .size_code (in_size),
        .legal     (size_ok),
        .off_w     (off_w),
        .off_mask  (off_mask)
    );

    pg_rights u_rights (
        .acc      (in_acc),
        .user     (in_user),
        .perm     (in_perm),
        .allow    (allow),
        .is_fetch (is_fetch)
    );

    assign page_base  = {in_rpn, {BASE_W{1'b0}}};
    assign misaligned = |(page_base & off_mask);
    assign bad        = !size_ok || misaligned;
    assign grant      = !bad && allow;
    assign ra         = grant ? ((page_base & ~off_mask) | (in_ea & off_mask)) : '0;

    assign res_d = {ra, grant,
                    !bad && !allow && is_fetch,
                    !bad && !allow && !is_fetch,
                    bad};

    pg_hold_stage #(.W(RES_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (res_q)
    );

    assign {out_ra, out_grant, out_xviol, out_dviol, out_bad} = res_q;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_ra,
    input logic              out_grant,
    input logic              out_xviol,
    input logic              out_dviol,
    input logic              out_bad
);
    p_bad_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bad |-> !out_grant && !out_xviol && !out_dviol);

    p_flags_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_xviol, out_dviol, out_bad}));

    p_grant_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_grant |-> !out_xviol && !out_dviol);

    p_ra_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_grant |-> out_ra == '0);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ra) && $stable(out_grant)
            && $stable(out_xviol) && $stable(out_dviol) && $stable(out_bad));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind page_guard pg_checker #(.ADDR_W(ADDR_W)) u_pg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ra    (out_ra),
    .out_grant (out_grant),
    .out_xviol (out_xviol),
    .out_dviol (out_dviol),
    .out_bad   (out_bad)
);

// File: tb/tb_page_guard.sv
module tb_page_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_ea = '0;
    logic [1:0]  in_acc = '0;
    logic        in_user = 1'b0;
    logic [3:0]  in_size = '0;
    logic [21:0] in_rpn = '0;
    logic [5:0]  in_perm = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_ra;
    logic        out_grant, out_xviol, out_dviol, out_bad;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    page_guard dut (.*);

    task automatic cmp(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int exp_w(input logic [3:0] s);
        case (s)
            4'd0: return 10; 4'd1: return 12; 4'd2: return 14; 4'd3: return 16;
            4'd4: return 18; 4'd5: return 20; 4'd7: return 24; 4'd9: return 28;
            default: return -1;
        endcase
    endfunction

    function automatic logic [35:0] model(input logic [31:0] ea, input logic [1:0] acc,
            input logic usr, input logic [3:0] s, input logic [21:0] rpn, input logic [5:0] pm);
        int w = exp_w(s);
        logic bad, ok;
        logic [31:0] m, ra;
        bad = (w < 0);
        m = (w < 0) ? 32'h0 : ((32'h1 << w) - 1);
        if (!bad && ((({rpn, 10'b0}) & m) != 0)) bad = 1'b1;
        case (acc)
            2'd0:    ok = usr ? pm[5] : pm[2];
            2'd1:    ok = usr ? pm[3] : pm[0];
            default: ok = usr ? pm[4] : pm[1];
        endcase
        ra = (!bad && ok) ? (({rpn, 10'b0} & ~m) | (ea & m)) : 32'h0;
        return {ra, !bad && ok, !bad && !ok && acc == 2'd0, !bad && !ok && acc != 2'd0, bad};
    endfunction

    task automatic drive(input logic [31:0] ea, input logic [1:0] acc, input logic usr,
            input logic [3:0] s, input logic [21:0] rpn, input logic [5:0] pm);
        in_valid = 1'b1; in_ea = ea; in_acc = acc; in_user = usr;
        in_size = s; in_rpn = rpn; in_perm = pm;
    endtask

    task automatic txn(input string tag, input logic [31:0] ea, input logic [1:0] acc,
            input logic usr, input logic [3:0] s, input logic [21:0] rpn, input logic [5:0] pm);
        @(negedge clk);
        drive(ea, acc, usr, s, rpn, pm);
        @(negedge clk);
        in_valid = 1'b0;
        cmp(tag, {out_ra, out_grant, out_xviol, out_dviol, out_bad},
            model(ea, acc, usr, s, rpn, pm));
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [35:0] held;
        repeat (3) @(negedge clk);
        cmp("R10 reset", {34'b0, out_valid, in_ready}, {34'b0, 1'b0, 1'b1});
        rst_n = 1'b1;

        // R1 R2 R3: every size code with aligned and misaligned page numbers
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 4; p++) begin
                int w = exp_w(4'(s));
                logic [21:0] rpn = 22'h3A5F3C ^ 22'(p * 22'h11111);
                logic [31:0] ea  = 32'hC3A5_96E1 ^ (32'h0101_0101 * p);
                if (w > 10) rpn = rpn & ~((22'h1 << (w - 10)) - 1);
                if (p == 3 && w > 10) rpn = rpn | (22'h1 << (w - 11));
                if (p == 2 && w > 12) rpn = rpn | 22'h1;
                txn(w < 0 ? "R2 size" : (p >= 2 ? "R3 align" : "R1 form"),
                    ea, 2'(p), 1'b1, 4'(s), rpn, 6'h3F);
            end
        end

        // R4 R5 R6 R7 R8: all rights x access kinds x modes, valid and invalid entry
        for (int pm = 0; pm < 64; pm++) begin
            for (int a = 0; a < 4; a++) begin
                for (int u = 0; u < 2; u++) begin
                    string t = (a == 0) ? "R4 exec" : (a == 1) ? "R5 read" : "R6 write";
                    txn(t, 32'h1234_5678 + 32'(pm), 2'(a), 1'(u), 4'd1, 22'h2AAAA8, 6'(pm));
                end
            end
            txn("R7 bad wins", 32'hFFFF_FFFF, 2'(pm % 4), 1'(pm % 2), 4'd8, 22'h3FFFFF, 6'(pm));
            txn("R8 ra zero", 32'h0000_0ABC, 2'd2, 1'b0, 4'd3, 22'h0000F3, 6'(pm));
        end

        // R9: stall and release
        @(negedge clk);
        out_ready = 1'b0;
        drive(32'h0000_1111, 2'd1, 1'b0, 4'd0, 22'h155555, 6'h01);
        @(negedge clk);
        held = {out_ra, out_grant, out_xviol, out_dviol, out_bad};
        cmp("R9 latency", {35'b0, out_valid}, 36'd1);
        cmp("R9 first", held, model(32'h0000_1111, 2'd1, 1'b0, 4'd0, 22'h155555, 6'h01));
        drive(32'h0000_2222, 2'd0, 1'b1, 4'd0, 22'h0AAAAA, 6'h20);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            cmp("R9 hold", {out_ra, out_grant, out_xviol, out_dviol, out_bad}, held);
            cmp("R9 stall", {34'b0, out_valid, in_ready}, {34'b0, 1'b1, 1'b0});
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R9 release", {out_ra, out_grant, out_xviol, out_dviol, out_bad},
            model(32'h0000_2222, 2'd0, 1'b1, 4'd0, 22'h0AAAAA, 6'h20));
        @(negedge clk);
        cmp("R9 drain", {34'b0, out_valid, in_ready}, {34'b0, 1'b0, 1'b1});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule